// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and date as a chain of binary-coded decimal digits, each held in its own 4-bit register: seconds, minutes and hours as units/tens pairs, a single day-of-week digit, and units/tens pairs for day of month, month and a two-digit year. The chain is clocked by the system clock. A qualifier input marks each cycle in which the 32768 Hz oscillator has produced an edge. A prescaler turns these pulses into a one-second step, and the prescaler and the chain only move while the timer-enable input is high.

A 2-bit leap counter steps on every year carry, and it selects the February length. An adjust input rounds the seconds to the nearest minute on its rising edge. A neighbouring register file reads every digit through a flat output bus. It loads a single digit through a write port. Alarm logic gets a one-cycle strobe each time the minutes field steps.

Top module: `tod_calendar`

## Requirements
- R1: After reset the digits read 00:00:00, day of week 0, day 01, month 01, year 00. The leap counter is 0 and the minute strobe is low.
- R2: A seconds step occurs on the OSC_DIV-th cycle, counted among cycles with both the oscillator qualifier and timer enable high. With timer enable low, the prescaler and all digits hold.
- R3: Seconds and minutes each wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into day of month and day of week.
- R4: Day of week (digit index 6) counts 0 to 6 and wraps to 0 on an hour carry.
- R5: Day of month returns to 01 after the last day of the month and carries into the month. Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31, and February has 29 days when the leap counter is 0. Month wraps from 12 to 01 and carries into the year.
- R6: The year wraps from 99 to 00. Every year carry increments the 2-bit leap counter modulo 4, and nothing else changes it.
- R7: On a rising edge of the adjust input, seconds below 30 clear to 00. Seconds of 30 or more clear to 00 and step the minutes, with full carry.
- R8: When an adjust edge and a seconds step fall in the same cycle, only the adjust takes effect, and that seconds step is lost.
- R9: The minute strobe is high for exactly the one cycle after any minutes step, including an adjust round-up. It never rises because of a digit write.
- R10: A write places the data in the digit whose index is given. The index layout is: 0 sec units, 1 sec tens, 2 min units, 3 min tens, 4 hour units, 5 hour tens, 6 day of week, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens. A write wins over any step or adjust in its cycle, which is discarded. Indices 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One-cycle qualifier per oscillator edge |
| timerEn | input | 1 | Timer enable from the mode register |
| adjIn | input | 1 | Adjust request, acted on at its rising edge |
| wrEn | input | 1 | Digit write strobe |
| wrIdx | input | 4 | Digit index for the write |
| wrData | input | 4 | Digit value to store |
| digits | output | 52 | All 13 digits, digit i at bits 4i+3..4i |
| leapCount | output | 2 | Leap-year counter |
| minuteTick | output | 1 | One-cycle strobe after a minutes step |

## Verification
A seconds step and an adjust edge can land in the same cycle. A digit write can also coincide with either of them. The bench walks the prescaler to its last count, with the seconds preset to 45, and raises adjust on the cycle that would step. It then expects 00 seconds and a single minute step, not 46 seconds. It repeats the same alignment with a write, and expects only the written digit to change. Random runs also let adjust edges, writes and oscillator pulses collide freely, and they compare every digit against a calendar model in the bench.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_DIGITS = 13;
  localparam int DIGIT_W    = 4;
  localparam int BUS_W      = NUM_DIGITS * DIGIT_W;

  localparam int IDX_SEC1  = 0;
  localparam int IDX_SEC10 = 1;
  localparam int IDX_MIN1  = 2;
  localparam int IDX_MIN10 = 3;
  localparam int IDX_HR1   = 4;
  localparam int IDX_HR10  = 5;
  localparam int IDX_DOW   = 6;
  localparam int IDX_DAY1  = 7;
  localparam int IDX_DAY10 = 8;
  localparam int IDX_MON1  = 9;
  localparam int IDX_MON10 = 10;
  localparam int IDX_YR1   = 11;
  localparam int IDX_YR10  = 12;

  typedef struct packed {
    logic secTick;
    logic adjRound;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int OSC_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       timerEn,
  input  logic       adjIn,
  output todStrobe_t strobe
);
  localparam int PW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(OSC_DIV - 1);

  logic [PW-1:0] preCnt;
  logic          adjQ;
  logic          run;

  assign run = oscEn & timerEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      adjQ   <= 1'b0;
    end else begin
      adjQ <= adjIn;
      if (run) preCnt <= (preCnt == LAST) ? '0 : preCnt + 1'b1;
    end
  end

  assign strobe.secTick  = run & (preCnt == LAST);
  assign strobe.adjRound = adjIn & ~adjQ;

  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |=> $stable(preCnt)); // R2
  AST_ADJ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adjRound |=> !strobe.adjRound); // R7
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  todStrobe_t         strobe,
  input  logic               wrEn,
  input  logic [3:0]         wrIdx,
  input  logic [DIGIT_W-1:0] wrData,
  output logic [BUS_W-1:0]   digits,
  output logic [1:0]         leapCount,
  output logic               minuteTick
);
  logic [DIGIT_W-1:0] dq [NUM_DIGITS];
  logic [DIGIT_W-1:0] dn [NUM_DIGITS];
  logic [1:0] leapQ, leapN;
  logic minStep, hrStep, dayStep, monStep, yrStep;
  logic minuteTickQ;

  function automatic logic [6:0] toBin(logic [3:0] hi, logic [3:0] lo);
    return ({3'b0, hi} * 7'd10) + {3'b0, lo};
  endfunction

  function automatic logic [7:0] bcdInc(logic [3:0] hi, logic [3:0] lo);
    if (lo >= 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  function automatic logic [6:0] monthDays(logic [6:0] mon, logic [1:0] leap);
    case (mon)
      7'd2:                       return (leap == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_DIGITS; i++) dn[i] = dq[i];
    leapN   = leapQ;
    minStep = 1'b0;
    hrStep  = 1'b0;
    dayStep = 1'b0;
    monStep = 1'b0;
    yrStep  = 1'b0;

    if (strobe.adjRound) begin
      dn[IDX_SEC1]  = '0;
      dn[IDX_SEC10] = '0;
      minStep = (dq[IDX_SEC10] >= 4'd3);
    end else if (strobe.secTick) begin
      if (toBin(dq[IDX_SEC10], dq[IDX_SEC1]) >= 7'd59) begin
        dn[IDX_SEC1]  = '0;
        dn[IDX_SEC10] = '0;
        minStep = 1'b1;
      end else begin
        {dn[IDX_SEC10], dn[IDX_SEC1]} = bcdInc(dq[IDX_SEC10], dq[IDX_SEC1]);
      end
    end

    if (minStep) begin
      if (toBin(dq[IDX_MIN10], dq[IDX_MIN1]) >= 7'd59) begin
        dn[IDX_MIN1]  = '0;
        dn[IDX_MIN10] = '0;
        hrStep = 1'b1;
      end else begin
        {dn[IDX_MIN10], dn[IDX_MIN1]} = bcdInc(dq[IDX_MIN10], dq[IDX_MIN1]);
      end
    end

    if (hrStep) begin
      if (toBin(dq[IDX_HR10], dq[IDX_HR1]) >= 7'd23) begin
        dn[IDX_HR1]  = '0;
        dn[IDX_HR10] = '0;
        dayStep = 1'b1;
      end else begin
        {dn[IDX_HR10], dn[IDX_HR1]} = bcdInc(dq[IDX_HR10], dq[IDX_HR1]);
      end
    end

    if (dayStep) begin
      dn[IDX_DOW] = (dq[IDX_DOW] >= 4'd6) ? 4'd0 : dq[IDX_DOW] + 4'd1;
      if (toBin(dq[IDX_DAY10], dq[IDX_DAY1]) >=
          monthDays(toBin(dq[IDX_MON10], dq[IDX_MON1]), leapQ)) begin
        dn[IDX_DAY1]  = 4'd1;
        dn[IDX_DAY10] = 4'd0;
        monStep = 1'b1;
      end else begin
        {dn[IDX_DAY10], dn[IDX_DAY1]} = bcdInc(dq[IDX_DAY10], dq[IDX_DAY1]);
      end
    end

    if (monStep) begin
      if (toBin(dq[IDX_MON10], dq[IDX_MON1]) >= 7'd12) begin
        dn[IDX_MON1]  = 4'd1;
        dn[IDX_MON10] = 4'd0;
        yrStep = 1'b1;
      end else begin
        {dn[IDX_MON10], dn[IDX_MON1]} = bcdInc(dq[IDX_MON10], dq[IDX_MON1]);
      end
    end

    if (yrStep) begin
      leapN = leapQ + 2'd1;
      if (toBin(dq[IDX_YR10], dq[IDX_YR1]) >= 7'd99) begin
        dn[IDX_YR1]  = '0;
        dn[IDX_YR10] = '0;
      end else begin
        {dn[IDX_YR10], dn[IDX_YR1]} = bcdInc(dq[IDX_YR10], dq[IDX_YR1]);
      end
    end

    if (wrEn) begin
      for (int i = 0; i < NUM_DIGITS; i++)
        dn[i] = (wrIdx == 4'(i)) ? wrData : dq[i];
      leapN   = leapQ;
      minStep = 1'b0;
      yrStep  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIGITS; i++)
        dq[i] <= (i == IDX_DAY1 || i == IDX_MON1) ? 4'd1 : 4'd0;
      leapQ       <= 2'd0;
      minuteTickQ <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_DIGITS; i++) dq[i] <= dn[i];
      leapQ       <= leapN;
      minuteTickQ <= minStep;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gFlat
    assign digits[g*DIGIT_W +: DIGIT_W] = dq[g];
  end
  assign leapCount  = leapQ;
  assign minuteTick = minuteTickQ;

  AST_ADJ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adjRound && !wrEn |=> (dq[IDX_SEC1] == 4'd0 && dq[IDX_SEC10] == 4'd0)); // R7
  AST_ADJ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adjRound && strobe.secTick && !wrEn |=> dq[IDX_SEC1] == 4'd0); // R8
  AST_LEAP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(leapQ) |-> $past(yrStep)); // R6
  AST_MIN_TICK_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    minuteTickQ |-> !$stable({dq[IDX_MIN10], dq[IDX_MIN1]})); // R9
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int OSC_DIV = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscEn,
  input  logic             timerEn,
  input  logic             adjIn,
  input  logic             wrEn,
  input  logic [3:0]       wrIdx,
  input  logic [3:0]       wrData,
  output logic [BUS_W-1:0] digits,
  output logic [1:0]       leapCount,
  output logic             minuteTick
);
  todStrobe_t strobe;

  tod_ctrl #(.OSC_DIV(OSC_DIV)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .oscEn   (oscEn),
    .timerEn (timerEn),
    .adjIn   (adjIn),
    .strobe  (strobe)
  );

  tod_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .digits     (digits),
    .leapCount  (leapCount),
    .minuteTick (minuteTick)
  );
endmodule

// File: tb/tb_tod_calendar.sv
module tb_tod_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b0, timerEn = 1'b0, adjIn = 1'b0, wrEn = 1'b0;
  logic [3:0] wrIdx = '0, wrData = '0;
  logic [51:0] digits;
  logic [1:0] leapCount;
  logic minuteTick;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference calendar state
  int mPre, mSec, mMin, mHr, mDow, mDay, mMon, mYr, mLeap;
  bit mAdjQ, mTick;

  tod_calendar #(.OSC_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .timerEn(timerEn), .adjIn(adjIn),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .digits(digits), .leapCount(leapCount), .minuteTick(minuteTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int monLen(int mon, int leap);
    if (mon == 2) return (leap == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [51:0] expDigits();
    logic [51:0] v;
    int f[13];
    f[0] = mSec % 10; f[1] = mSec / 10; f[2] = mMin % 10; f[3] = mMin / 10;
    f[4] = mHr % 10;  f[5] = mHr / 10;  f[6] = mDow;
    f[7] = mDay % 10; f[8] = mDay / 10; f[9] = mMon % 10; f[10] = mMon / 10;
    f[11] = mYr % 10; f[12] = mYr / 10;
    for (int i = 0; i < 13; i++) v[i*4 +: 4] = 4'(f[i]);
    return v;
  endfunction

  function automatic int setD(int val, int d, bit tens);
    return tens ? d * 10 + val % 10 : (val / 10) * 10 + d;
  endfunction

  task automatic modelMinute();
    mTick = 1;
    mMin++;
    if (mMin == 60) begin
      mMin = 0; mHr++;
      if (mHr == 24) begin
        mHr = 0;
        mDow = (mDow == 6) ? 0 : mDow + 1;
        mDay++;
        if (mDay > monLen(mMon, mLeap)) begin
          mDay = 1; mMon++;
          if (mMon == 13) begin
            mMon = 1; mLeap = (mLeap + 1) % 4;
            mYr = (mYr == 99) ? 0 : mYr + 1;
          end
        end
      end
    end
  endtask

  task automatic modelStep(bit osc, bit ten, bit adj, bit we, int idx, int dat);
    bit tick, rise;
    tick = osc && ten && (mPre == DIV - 1);
    if (osc && ten) mPre = (mPre == DIV - 1) ? 0 : mPre + 1;
    rise = adj && !mAdjQ;
    mAdjQ = adj;
    mTick = 0;
    if (we) begin
      case (idx)
        0: mSec = setD(mSec, dat, 0);   1: mSec = setD(mSec, dat, 1);
        2: mMin = setD(mMin, dat, 0);   3: mMin = setD(mMin, dat, 1);
        4: mHr  = setD(mHr, dat, 0);    5: mHr  = setD(mHr, dat, 1);
        6: mDow = dat;
        7: mDay = setD(mDay, dat, 0);   8: mDay = setD(mDay, dat, 1);
        9: mMon = setD(mMon, dat, 0);  10: mMon = setD(mMon, dat, 1);
        11: mYr = setD(mYr, dat, 0);   12: mYr  = setD(mYr, dat, 1);
        default: ;
      endcase
    end else if (rise) begin
      if (mSec >= 30) begin mSec = 0; modelMinute(); end
      else mSec = 0;
    end else if (tick) begin
      mSec++;
      if (mSec == 60) begin mSec = 0; modelMinute(); end
    end
  endtask

  task automatic cyc(bit osc, bit ten, bit adj, bit we, int idx, int dat);
    oscEn = osc; timerEn = ten; adjIn = adj; wrEn = we;
    wrIdx = 4'(idx); wrData = 4'(dat);
    modelStep(osc, ten, adj, we, idx, dat);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic checkAll(string tag);
    logic [51:0] e;
    e = expDigits();
    nChecks++;
    if (digits !== e || leapCount !== 2'(mLeap) || minuteTick !== mTick) begin
      nFail++;
      $display("FAIL %s: digits=%h leap=%0d tick=%0b expected digits=%h leap=%0d tick=%0b",
               tag, digits, leapCount, minuteTick, e, mLeap, mTick);
    end
  endtask

  task automatic checkVal(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dg(int i);
    return int'(digits[i*4 +: 4]);
  endfunction

  task automatic preset(int h, int m, int s, int dw, int d, int mo, int y);
    int v[13];
    v[0] = s % 10; v[1] = s / 10; v[2] = m % 10; v[3] = m / 10;
    v[4] = h % 10; v[5] = h / 10; v[6] = dw;
    v[7] = d % 10; v[8] = d / 10; v[9] = mo % 10; v[10] = mo / 10;
    v[11] = y % 10; v[12] = y / 10;
    for (int i = 0; i < 13; i++) cyc(0, 1, 0, 1, i, v[i]);
  endtask

  task automatic tickOnce();
    int start;
    start = mSec + 60 * mMin;
    for (int k = 0; k < 2 * DIV; k++) begin
      cyc(1, 1, 0, 0, 0, 0);
      if (mSec + 60 * mMin != start) break;
    end
  endtask

  task automatic alignPre();
    while (mPre != DIV - 1) cyc(1, 1, 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [51:0] snap;
    int pm, psec;
    void'($urandom(32'd20240611));
    mPre = 0; mSec = 0; mMin = 0; mHr = 0; mDow = 0; mDay = 1; mMon = 1;
    mYr = 0; mLeap = 0; mAdjQ = 0; mTick = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    checkAll("R1 reset");
    checkVal("R1 day units", dg(7), 1);
    checkVal("R1 month units", dg(9), 1);

    // R2 one step after exactly DIV qualified pulses
    for (int k = 0; k < DIV - 1; k++) cyc(1, 1, 0, 0, 0, 0);
    checkVal("R2 no step yet", dg(0), 0);
    cyc(1, 1, 0, 0, 0, 0);
    checkVal("R2 step on last pulse", dg(0), 1);
    // R2 hold while disabled
    snap = digits;
    for (int k = 0; k < 3 * DIV; k++) cyc(1, 0, 0, 0, 0, 0);
    checkVal("R2 hold when disabled", int'(digits == snap), 1);
    checkAll("R2 hold model");

    // R3 and R4 full rollover at year end, R6 leap step
    preset(23, 59, 58, 6, 31, 12, 99);
    tickOnce(); checkAll("R3 pre-rollover");
    tickOnce(); checkAll("R3 rollover");
    checkVal("R4 dow wrap", dg(6), 0);
    checkVal("R6 year wrap tens", dg(12), 0);
    checkVal("R6 leap step", leapCount, 1);
    checkVal("R9 minute strobe on carry", minuteTick, 1);
    cyc(0, 1, 0, 0, 0, 0);
    checkVal("R9 strobe single cycle", minuteTick, 0);

    // R5 Feb 28 with leap=1 goes to Mar 1
    preset(23, 59, 59, 2, 28, 2, 0);
    tickOnce(); checkAll("R5 feb28 nonleap");
    checkVal("R5 march after 28", dg(9), 3);
    // R5 Apr 30 -> May 1
    preset(23, 59, 59, 3, 30, 4, 5);
    tickOnce(); checkAll("R5 apr30");
    checkVal("R5 may", dg(9), 5);

    // R6 bring leap to 0 through three more year carries
    for (int k = 0; k < 3; k++) begin
      preset(23, 59, 59, 1, 31, 12, 40 + k);
      tickOnce();
    end
    checkAll("R6 leap mod4");
    checkVal("R6 leap back to zero", leapCount, 0);

    // R5 leap year February has 29 days
    preset(23, 59, 59, 4, 28, 2, 44);
    tickOnce(); checkAll("R5 feb29 exists");
    checkVal("R5 day 29", dg(7), 9);
    preset(23, 59, 59, 5, 29, 2, 44);
    tickOnce(); checkAll("R5 feb29 to mar1");

    // R7 adjust below 30
    preset(10, 20, 29, 0, 15, 6, 30);
    cyc(0, 1, 1, 0, 0, 0); checkAll("R7 adjust low");
    checkVal("R7 minutes kept", dg(2), 0);
    checkVal("R9 no strobe on low adjust", minuteTick, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R7 adjust at 30 rounds up
    cyc(0, 1, 0, 1, 1, 3);
    cyc(0, 1, 1, 0, 0, 0); checkAll("R7 adjust high");
    checkVal("R7 minute stepped", dg(2), 1);
    checkVal("R9 strobe on round-up", minuteTick, 1);
    cyc(0, 1, 0, 0, 0, 0);

    // R8 adjust and step in same cycle
    alignPre();
    cyc(0, 1, 0, 1, 1, 4);
    cyc(0, 1, 0, 1, 0, 5);
    pm = dg(2);
    cyc(1, 1, 1, 0, 0, 0); checkAll("R8 collision");
    checkVal("R8 seconds cleared", dg(0) + 10 * dg(1), 0);
    checkVal("R8 one minute step", dg(2), (pm + 1) % 10);
    cyc(0, 1, 0, 0, 0, 0);

    // R10 write wins over a seconds step, unused index ignored
    alignPre();
    psec = dg(0);
    cyc(1, 1, 0, 1, 2, 7); checkAll("R10 write beats step");
    checkVal("R10 seconds unchanged", dg(0), psec);
    checkVal("R10 written digit", dg(2), 7);
    checkVal("R9 no strobe on write", minuteTick, 0);
    snap = digits;
    cyc(0, 1, 0, 1, 13, 9); cyc(0, 1, 0, 1, 15, 9);
    checkVal("R10 index 13-15 ignored", int'(digits == snap), 1);

    // random phase
    begin
      bit adjL;
      adjL = 0;
      for (int n = 0; n < 6000; n++) begin
        bit osc, ten, we;
        int idx, dat, r;
        osc = ($urandom % 100) < 60;
        ten = ($urandom % 10) != 0;
        if (($urandom % 100) < 5) adjL = !adjL;
        we = ($urandom % 100) < 3;
        r = $urandom % 4;
        idx = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 2 : 14;
        dat = (idx == 1) ? $urandom % 6 : $urandom % 10;
        cyc(osc, ten, adjL, we, idx, dat);
        checkAll("R3 random");
      end
    end
    summary();
  end
endmodule